// File: doc/BRIEF.md
# Synchronous Byte FIFO Bus Master

This block sits on the host-facing side of a USB bridge that runs its 8-bit FIFO link in synchronous mode. The bridge supplies a 60 MHz clock, and the block runs entirely on it. The bridge reports its own state on two active-low flags. One flag says received bytes are waiting. The other says its transmit buffer has room. Both flags can change on every cycle. The block drives the output-enable, read and write strobes (all active low) and shares the data lines with the bridge. The shared lines are modelled as an input bus, an output bus and an enable for the local drivers.

Inside the chip, the block presents two byte streams with valid/ready handshakes. One stream is a sink for bytes coming out of the bridge. The other is a source for bytes going into the bridge. An arbiter chooses one bus direction at a time:
- Reading wins when both directions want the bus.
- A burst limit makes each direction give way to the other after a set number of bytes.
- Output-enable always goes low a full cycle before the read strobe.
- The local drivers stay off until the bridge has released the lines.

The write side holds up to two bytes: the byte on the bus and one spare. A byte offered while the bridge stops accepting stays held and is offered again.

Top module: `sfifo_bus_master`

## Requirements
- R1: During reset and in the first cycle after it, the output-enable, read and write strobes are high (inactive), `bus_oe` is 0, `rx_valid` is 0 and `tx_ready` is 1.
- R2: The read strobe is low in a cycle only if output-enable was already low in the previous cycle.
- R3: A byte goes to the sink exactly at a clock edge where the receive flag, output-enable and the read strobe are all low. In that cycle `rx_valid` and `rx_ready` are both 1, and `rx_data` equals `bus_i`. Bytes reach the sink in the order the bridge presents them.
- R4: The read strobe is high in every cycle where the receive flag is high or `rx_ready` is 0.
- R5: `bus_oe` is 0 whenever output-enable is low, and in the first cycle after output-enable returns high.
- R6: The write strobe is low only while `bus_oe` is 1. The read and write strobes are never low together. A byte counts as written at an edge where the write strobe and the transmit flag are both low. Bytes leave in the order the source gave them.
- R7: If the write strobe is low while the transmit flag is high at an edge, `bus_o` keeps its value into the next cycle. Stalls never lose or repeat a byte.
- R8: From idle, when bytes are waiting to be read and a write is also ready at the same edge, the read is done first.
- R9: A read burst stops after `BURST_MAX` bytes if a write is ready with the transmit flag low, and the write then gets the bus next. A write burst stops after `BURST_MAX` bytes if the receive flag is low.
- R10: While the transmit flag is held high, the block accepts exactly two bytes from the source and then holds `tx_ready` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 60 MHz clock supplied by the bridge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxf_n | input | 1 | Low when the bridge holds received bytes |
| txe_n | input | 1 | Low when the bridge can take a byte |
| oe_n | output | 1 | Low to let the bridge drive the data lines |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_i | input | DATA_W | Data lines as seen at the pads |
| bus_o | output | DATA_W | Value the local drivers put on the data lines |
| bus_oe | output | 1 | Enables the local data drivers |
| rx_data | output | DATA_W | Byte to the sink |
| rx_valid | output | 1 | A byte is on `rx_data` |
| rx_ready | input | 1 | Sink can take a byte |
| tx_data | input | DATA_W | Byte from the source |
| tx_valid | input | 1 | Source offers a byte |
| tx_ready | output | 1 | Block can take a byte |

## Verification
Two functions can collide at a single clock edge. One is a read request from the bridge. The other is a write that is ready to go: bytes are already held in the block and the transmit flag has just dropped. The bench sets this up by filling the write side while the transmit flag is held high. Then, in one cycle, it lowers that flag and fills the bridge model's receive queue, so both requests reach the idle arbiter together. The bench records the order of bus transfers and compares it with the sequence that read priority and the burst limit predict. The turnaround rules are checked on every cycle of that exchange.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_TURN = 3'd1,
        ST_RD_ACT  = 3'd2,
        ST_RD_REL  = 3'd3,
        ST_WR      = 3'd4
    } sfb_state_e;

    // The bridge owns the data lines in these states.
    function automatic logic bridge_owns_bus(sfb_state_e s);
        return (s == ST_RD_TURN) || (s == ST_RD_ACT);
    endfunction

endpackage

// File: rtl/sfb_arbiter.sv
module sfb_arbiter
    import sfb_pkg::*;
#(
    parameter int BURST_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pend,
    input  logic       tx_have,
    input  logic       tx_open,
    input  logic       rd_fire,
    input  logic       wr_fire,
    output sfb_state_e st_o
);
    localparam int CNT_W = $clog2(BURST_MAX + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BURST_MAX);

    typedef struct packed {
        sfb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             owed;
    } arb_t;

    arb_t q, d;
    logic             wr_pend;
    logic             fire;
    logic [CNT_W-1:0] cnt_inc;
    logic             hit;

    always_comb begin
        wr_pend = tx_have && tx_open;
        fire    = (q.st == ST_RD_ACT) ? rd_fire : wr_fire;
        cnt_inc = (q.cnt == CAP) ? q.cnt : q.cnt + CNT_W'(fire);
        hit     = (cnt_inc >= CAP);
        d       = q;
        case (q.st)
            ST_IDLE: begin
                d.cnt = '0;
                if (q.owed && wr_pend) begin
                    d.st   = ST_WR;
                    d.owed = 1'b0;
                end else if (rx_pend) begin
                    d.st = ST_RD_TURN;
                end else if (wr_pend) begin
                    d.st   = ST_WR;
                    d.owed = 1'b0;
                end
            end
            ST_RD_TURN: d.st = ST_RD_ACT;
            ST_RD_ACT: begin
                d.cnt = cnt_inc;
                if (!rx_pend) begin
                    d.st = ST_RD_REL;
                end else if (hit && wr_pend) begin
                    d.st   = ST_RD_REL;
                    d.owed = 1'b1;
                end
            end
            ST_RD_REL: d.st = ST_IDLE;
            ST_WR: begin
                d.cnt = cnt_inc;
                if (!tx_have) begin
                    d.st = ST_IDLE;
                end else if (rx_pend && (!tx_open || hit)) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, owed: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign st_o = q.st;

    // R8: reads go first from idle unless the write side is owed a turn
    a_r8_read_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && rx_pend && !q.owed) |=> (q.st == ST_RD_TURN));

    // R9: a read burst never carries past the cap while a write waits
    a_r9_read_yields: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RD_ACT && q.cnt == CAP && wr_pend) |=> (q.st != ST_RD_ACT));

endmodule

// File: rtl/sfb_tx_skid.sv
module sfb_tx_skid #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_take
);
    typedef struct packed {
        logic              out_v;
        logic [DATA_W-1:0] out_d;
        logic              sk_v;
        logic [DATA_W-1:0] sk_d;
    } skid_t;

    skid_t q, d;
    logic  in_fire;
    logic  out_free;

    always_comb begin
        in_fire  = in_valid && !q.sk_v;
        out_free = !q.out_v || out_take;
        d        = q;
        if (q.sk_v) begin
            if (out_free) begin
                d.out_v = 1'b1;
                d.out_d = q.sk_d;
                d.sk_v  = 1'b0;
            end
        end else begin
            if (out_take) begin
                d.out_v = 1'b0;
            end
            if (in_fire) begin
                if (out_free) begin
                    d.out_v = 1'b1;
                    d.out_d = in_data;
                end else begin
                    d.sk_v = 1'b1;
                    d.sk_d = in_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = !q.sk_v;
    assign out_valid = q.out_v;
    assign out_data  = q.out_d;

    // R10: the spare entry only fills behind an occupied bus entry
    a_r10_spare_behind_head: assert property (@(posedge clk) disable iff (!rst_n)
        q.sk_v |-> q.out_v);

    // R7: an untaken head byte stays put
    a_r7_head_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.out_v && !out_take) |=> (q.out_v && $stable(q.out_d)));

endmodule

// File: rtl/sfifo_bus_master.sv
module sfifo_bus_master
    import sfb_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int BURST_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxf_n,
    input  logic              txe_n,
    output logic              oe_n,
    output logic              rd_n,
    output logic              wr_n,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] bus_o,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    sfb_state_e        st;
    logic              head_v;
    logic [DATA_W-1:0] head_d;
    logic              rd_fire;
    logic              wr_fire;

    sfb_arbiter #(.BURST_MAX(BURST_MAX)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_pend (!rxf_n),
        .tx_have (head_v),
        .tx_open (!txe_n),
        .rd_fire (rd_fire),
        .wr_fire (wr_fire),
        .st_o    (st)
    );

    sfb_tx_skid #(.DATA_W(DATA_W)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (tx_valid),
        .in_ready  (tx_ready),
        .in_data   (tx_data),
        .out_valid (head_v),
        .out_data  (head_d),
        .out_take  (wr_fire)
    );

    always_comb begin
        oe_n     = !bridge_owns_bus(st);
        rx_valid = (st == ST_RD_ACT) && !rxf_n;
        rd_n     = !(rx_valid && rx_ready);
        rx_data  = bus_i;
        rd_fire  = !rd_n;
        bus_oe   = (st == ST_WR);
        wr_n     = !((st == ST_WR) && head_v);
        bus_o    = head_d;
        wr_fire  = !wr_n && !txe_n;
    end

    // R2: output-enable leads the read strobe by a full cycle
    a_r2_oe_leads_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> $past(!oe_n));

    // R5: no local drive while the bridge may drive
    a_r5_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !bus_oe);

    // R5: one quiet cycle after the bridge lets go
    a_r5_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> !bus_oe);

    // R6: write strobe only with drivers on, never with the read strobe
    a_r6_wr_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (bus_oe && rd_n));

    // R7: a refused byte is offered again unchanged
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && txe_n) |=> $stable(bus_o));

endmodule

// File: tb/sim_sfifo_bus_master.sv
`timescale 1ns/100ps
module sim_sfifo_bus_master;
    localparam int DW   = 8;
    localparam int BMAX = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxf_n = 1'b1;
    logic          txe_n = 1'b1;
    logic          oe_n, rd_n, wr_n, bus_oe;
    logic [DW-1:0] bus_i = '0;
    logic [DW-1:0] bus_o;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_ready = 1'b1;
    logic [DW-1:0] tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;

    always #2.5 clk = ~clk;

    sfifo_bus_master #(.DATA_W(DW), .BURST_MAX(BMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .rxf_n(rxf_n), .txe_n(txe_n),
        .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n),
        .bus_i(bus_i), .bus_o(bus_o), .bus_oe(bus_oe),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] br_rx[$];
    logic [DW-1:0] exp_rx[$];
    logic [DW-1:0] src_tx[$];
    logic [DW-1:0] exp_tx[$];
    logic [7:0]    dlog[$];
    int  ready_mode = 0;
    bit  txe_block = 1'b0;
    bit  txe_toggle = 1'b0;
    bit  logging = 1'b0;
    bit  p_rd = 1'b0;
    bit  p_tx = 1'b0;
    logic          prev_oe_n = 1'b1;
    logic          prev_wr_n = 1'b1;
    logic          prev_txe_n = 1'b1;
    logic [DW-1:0] prev_bus_o = '0;
    int  n_rd = 0;
    int  n_wr = 0;
    int  n_stall = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 40000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Bridge model and monitor: drive at the falling edge, sample 1 ns later
    always @(negedge clk) begin
        logic rdf, wrf;
        if (p_rd) void'(br_rx.pop_front());
        if (p_tx) void'(src_tx.pop_front());
        p_rd = 1'b0;
        p_tx = 1'b0;
        rxf_n    = (br_rx.size() == 0);
        bus_i    = (br_rx.size() != 0) ? br_rx[0] : '0;
        txe_n    = txe_block || (txe_toggle && (cyc % 5 == 2));
        rx_ready = (ready_mode == 0) || (cyc % 3 != 0);
        tx_valid = (src_tx.size() != 0);
        tx_data  = tx_valid ? src_tx[0] : '0;
        #1;
        if (rst_n) begin
            rdf = !rxf_n && !oe_n && !rd_n;
            wrf = !wr_n && !txe_n;
            if (!rd_n) chk(prev_oe_n == 1'b0, "R2 oe low before rd", int'(prev_oe_n), 0);
            if (bus_oe) chk(oe_n && prev_oe_n, "R5 drivers off near oe", int'({oe_n, prev_oe_n}), 3);
            if (rxf_n || !rx_ready) chk(rd_n == 1'b1, "R4 rd stops", int'(rd_n), 1);
            if (rdf) begin
                n_rd++;
                chk(rx_valid && rx_ready, "R3 handshake with bus read", int'(rx_valid && rx_ready), 1);
                if (exp_rx.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte", int'(rx_data), -1);
                end else begin
                    chk(rx_data == exp_rx[0], "R3 read data", int'(rx_data), int'(exp_rx[0]));
                    void'(exp_rx.pop_front());
                end
                p_rd = 1'b1;
                if (logging) dlog.push_back("R");
            end else if (rx_valid && rx_ready) begin
                chk(1'b0, "R3 handshake without bus read", 1, 0);
            end
            if (!wr_n) chk(bus_oe && rd_n, "R6 strobe needs drive", int'({bus_oe, rd_n}), 3);
            if (wrf) begin
                n_wr++;
                if (exp_tx.size() == 0) begin
                    chk(1'b0, "R6 unexpected write", int'(bus_o), -1);
                end else begin
                    chk(bus_o == exp_tx[0], "R6 write data", int'(bus_o), int'(exp_tx[0]));
                    void'(exp_tx.pop_front());
                end
                if (logging) dlog.push_back("W");
            end
            if (!prev_wr_n && prev_txe_n) begin
                n_stall++;
                chk(bus_o == prev_bus_o, "R7 stalled byte held", int'(bus_o), int'(prev_bus_o));
            end
            if (tx_valid && tx_ready) p_tx = 1'b1;
        end
        prev_oe_n  = oe_n;
        prev_wr_n  = wr_n;
        prev_txe_n = txe_n;
        prev_bus_o = bus_o;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic load_rx(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            br_rx.push_back(DW'(seed + i * 17));
            exp_rx.push_back(DW'(seed + i * 17));
        end
    endtask

    task automatic load_tx(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            src_tx.push_back(DW'(seed + i * 29));
            exp_tx.push_back(DW'(seed + i * 29));
        end
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while ((br_rx.size() + exp_rx.size() + src_tx.size() + exp_tx.size()) != 0 && t < 2000) begin
            step();
            t++;
        end
        chk(t < 2000, tag, t, 0);
        repeat (4) step();
    endtask

    initial begin
        logic [7:0] want[$];
        step();
        repeat (3) step();
        // R1 during reset
        chk(oe_n && rd_n && wr_n, "R1 strobes idle in reset", int'({oe_n, rd_n, wr_n}), 7);
        chk(!bus_oe && !rx_valid && tx_ready, "R1 drive/valid/ready in reset",
            int'({bus_oe, rx_valid, tx_ready}), 1);
        rst_n = 1'b1;
        step();
        chk(oe_n && rd_n && wr_n && !bus_oe, "R1 idle after reset",
            int'({oe_n, rd_n, wr_n, bus_oe}), 14);

        // Plain read stream
        load_rx(8, 3);
        drain("R3 read drain");
        chk(n_rd == 8, "R3 read count", n_rd, 8);

        // Read with a sink that pauses
        ready_mode = 1;
        load_rx(12, 100);
        drain("R4 paused sink drain");
        ready_mode = 0;
        chk(n_rd == 20, "R4 read count with pauses", n_rd, 20);

        // Write stream with the transmit flag dropping out
        txe_toggle = 1'b1;
        load_tx(9, 7);
        drain("R6 write drain");
        txe_toggle = 1'b0;
        chk(n_wr == 9, "R6 write count", n_wr, 9);
        chk(n_stall > 0, "R7 stall exercised", n_stall, 1);

        // Two-byte hold with the bridge refusing writes
        txe_block = 1'b1;
        load_tx(5, 50);
        repeat (10) step();
        chk(src_tx.size() == 3, "R10 bytes taken while blocked", 5 - src_tx.size(), 2);
        chk(tx_ready == 1'b0, "R10 tx_ready low when full", int'(tx_ready), 0);
        chk(n_wr == 9, "R10 nothing written while blocked", n_wr, 9);

        // Both directions become ready at the same edge
        dlog.delete();
        logging = 1'b1;
        txe_block = 1'b0;
        load_rx(10, 200);
        load_tx(5, 150);
        drain("R9 mixed drain");
        logging = 1'b0;
        for (int i = 0; i < BMAX; i++) want.push_back("R");
        for (int i = 0; i < BMAX; i++) want.push_back("W");
        for (int i = 0; i < BMAX; i++) want.push_back("R");
        for (int i = 0; i < BMAX; i++) want.push_back("W");
        for (int i = 0; i < 10 - 2 * BMAX; i++) want.push_back("R");
        for (int i = 0; i < 10 - 2 * BMAX; i++) want.push_back("W");
        chk(dlog.size() == want.size(), "R9 transfer count", dlog.size(), want.size());
        if (dlog.size() == want.size()) begin
            chk(dlog[0] == "R", "R8 read wins the shared edge", int'(dlog[0]), int'("R"));
            for (int i = 1; i < want.size(); i++)
                chk(dlog[i] == want[i], "R9 burst order", int'(dlog[i]), int'(want[i]));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule